// File: doc/BRIEF.md
# Accumulator Processor Core

A small 8-bit processor whose code and data share one 16-bit byte address space. Every instruction is a single byte. The high nibble selects the operation. The low nibble is either a register number, a zero-extended immediate or a branch condition. The core holds the program counter, a bank of sixteen 8-bit registers, an ALU and a three-phase sequencer. It drives a synchronous single-port memory. That memory returns read data in the cycle after the address and commits a write on the clock edge that ends a cycle in which the write enable is high.

Register 0 is the accumulator, and every arithmetic or logic result lands there. Registers 13 and 14 form a data pointer (high byte, low byte). Loads, stores and jump targets all go through this pointer. Register 15 holds the value that conditional instructions compare the accumulator against. Software builds wide constants by combining small immediates, register moves and loads.

Top module: `accum_core`

## Requirements
- R1: While `rst_n` is low, `mem_we` is 0 and `mem_addr` is 0x0000. All registers and the program counter reset to zero, so the first instruction is fetched from 0x0000 and the pointer starts at 0x0000.
- R2: The opcode is instruction bits [7:4]: 0 ADD, 1 ADDI, 2 SUB, 3 SUBI, 4 SKIP, 5 JUMP, 6 XOR, 7 XORI, 8 AND, 9 ANDI, A SET, B RB, C GET, D WB, E OR, F ORI. Every executed instruction takes exactly three cycles: fetch at the program counter, execute, writeback. The program counter then advances by one.
- R3: ADD/SUB use register[arg] and ADDI/SUBI use the zero-extended 4-bit argument. Each writes accumulator ± operand, modulo 256, back to the accumulator.
- R4: AND/OR/XOR (register operand) and ANDI/ORI/XORI (zero-extended immediate) write the bitwise result to the accumulator.
- R5: SET copies the accumulator into register[arg]. GET copies register[arg] into the accumulator.
- R6: WB writes register[arg] to address {R13,R14}. `mem_we` is high only in that instruction's writeback cycle.
- R7: RB loads register[arg] from address {R13,R14}. When the destination is the accumulator, it loads the accumulator. When it is a pointer register, the read uses the pointer as it was before the load.
- R8: Condition codes in bits [3:0] compare the accumulator with R15: 0 always, 1 equal, 2 not equal, 3 accumulator below R15 (unsigned), 4 accumulator above R15 (unsigned), 5 never.
- R9: A SKIP whose condition holds steps over the next instruction without spending cycles on it. A false SKIP continues in sequence. Neither changes any register.
- R10: A JUMP whose condition holds continues execution at {R13,R14}. A false JUMP continues in sequence.
- R11: Condition codes 6 to 15 never hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Memory address: program counter in fetch, data pointer otherwise |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |

## Verification
Two things can land in the same writeback cycle. A load can fetch through the pointer while it overwrites one of the pointer's own bytes, and a store can hit the very address the current instruction was fetched from. The program provokes both. It loads R14 through the pointer and then stores to the new address. It also stores to its own location after each jump. Each store is judged by its address and data, and by its distance in cycles from the first store: exactly three per executed instruction. That spacing also shows that skipped and jumped-over bytes cost nothing.

// File: rtl/accum_pkg.sv
package accum_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_ADDI = 4'h1, OP_SUB  = 4'h2, OP_SUBI = 4'h3,
    OP_SKIP = 4'h4, OP_JUMP = 4'h5, OP_XOR  = 4'h6, OP_XORI = 4'h7,
    OP_AND  = 4'h8, OP_ANDI = 4'h9, OP_SET  = 4'hA, OP_RB   = 4'hB,
    OP_GET  = 4'hC, OP_WB   = 4'hD, OP_OR   = 4'hE, OP_ORI  = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_WB    = 2'd2
  } phase_e;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0,
    CC_EQ     = 4'd1,
    CC_NE     = 4'd2,
    CC_LTU    = 4'd3,
    CC_GTU    = 4'd4,
    CC_NEVER  = 4'd5
  } cond_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_XOR, ALU_AND, ALU_OR, ALU_PASS
  } alu_op_e;

  localparam int OPC_W = 4;

endpackage

// File: rtl/accum_seq.sv
module accum_seq
  import accum_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);

  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_FETCH: phase_d = PH_EXEC;
      PH_EXEC:  phase_d = PH_WB;
      default:  phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FETCH;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/accum_regfile.sv
module accum_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] ptr_hi_o,
  output logic [DATA_W-1:0] ptr_lo_o,
  output logic [DATA_W-1:0] cmp_o
);

  localparam int NREG       = 1 << IDX_W;
  localparam int IDX_ACC    = 0;
  localparam int IDX_PTR_HI = NREG - 3;
  localparam int IDX_PTR_LO = NREG - 2;
  localparam int IDX_CMP    = NREG - 1;

  logic [DATA_W-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] q;

    assign en = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end

    assign bank[i] = q;
  end

  assign rd_data  = bank[rd_idx];
  assign acc_o    = bank[IDX_ACC];
  assign ptr_hi_o = bank[IDX_PTR_HI];
  assign ptr_lo_o = bank[IDX_PTR_LO];
  assign cmp_o    = bank[IDX_CMP];

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_XOR: y = a ^ b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/accum_cond.sv
module accum_cond
  import accum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        code,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] ref_val,
  output logic              hold
);

  always_comb begin
    case (cond_e'(code))
      CC_ALWAYS: hold = 1'b1;
      CC_EQ:     hold = (acc == ref_val);
      CC_NE:     hold = (acc != ref_val);
      CC_LTU:    hold = (acc <  ref_val);
      CC_GTU:    hold = (acc >  ref_val);
      default:   hold = 1'b0;
    endcase
  end

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic                  mem_we,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata
);

  localparam int ADDR_W = 2 * DATA_W;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  phase_e phase;

  accum_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .phase_o (phase)
  );

  // instruction register, loaded when the fetched byte arrives
  logic [DATA_W-1:0] ir_q, ir_d;
  logic              ir_en;
  opcode_e           opc;
  logic [IDX_W-1:0]  arg;

  assign ir_en = (phase == PH_EXEC);
  assign ir_d  = mem_rdata;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ir_q <= '0;
    else if (ir_en)  ir_q <= ir_d;
  end

  assign opc = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);
  assign arg = ir_q[IDX_W-1:0];

  // decode
  logic    is_imm, is_alu, in_wb;
  alu_op_e alu_op;

  always_comb begin
    is_imm = 1'b0;
    is_alu = 1'b1;
    alu_op = ALU_PASS;
    unique case (opc)
      OP_ADD:  alu_op = ALU_ADD;
      OP_ADDI: begin alu_op = ALU_ADD; is_imm = 1'b1; end
      OP_SUB:  alu_op = ALU_SUB;
      OP_SUBI: begin alu_op = ALU_SUB; is_imm = 1'b1; end
      OP_XOR:  alu_op = ALU_XOR;
      OP_XORI: begin alu_op = ALU_XOR; is_imm = 1'b1; end
      OP_AND:  alu_op = ALU_AND;
      OP_ANDI: begin alu_op = ALU_AND; is_imm = 1'b1; end
      OP_OR:   alu_op = ALU_OR;
      OP_ORI:  begin alu_op = ALU_OR;  is_imm = 1'b1; end
      OP_GET:  alu_op = ALU_PASS;
      default: is_alu = 1'b0;
    endcase
  end

  assign in_wb = (phase == PH_WB);

  // register file
  logic              rf_we;
  logic [IDX_W-1:0]  rf_widx;
  logic [DATA_W-1:0] rf_wdata, rf_rdata;
  logic [DATA_W-1:0] acc, ptr_hi, ptr_lo, cmp_val;
  logic [DATA_W-1:0] alu_b, alu_y;
  logic              cond_hold;

  accum_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (rf_we),
    .wr_idx   (rf_widx),
    .wr_data  (rf_wdata),
    .rd_idx   (arg),
    .rd_data  (rf_rdata),
    .acc_o    (acc),
    .ptr_hi_o (ptr_hi),
    .ptr_lo_o (ptr_lo),
    .cmp_o    (cmp_val)
  );

  assign alu_b = is_imm ? DATA_W'(arg) : rf_rdata;

  accum_alu #(.DATA_W(DATA_W)) u_alu (
    .op (alu_op),
    .a  (acc),
    .b  (alu_b),
    .y  (alu_y)
  );

  accum_cond #(.DATA_W(DATA_W)) u_cond (
    .code    (ir_q[3:0]),
    .acc     (acc),
    .ref_val (cmp_val),
    .hold    (cond_hold)
  );

  always_comb begin
    rf_we    = in_wb && (is_alu || opc == OP_SET || opc == OP_RB);
    rf_widx  = '0;
    rf_wdata = alu_y;
    if (opc == OP_SET) begin
      rf_widx  = arg;
      rf_wdata = acc;
    end else if (opc == OP_RB) begin
      rf_widx  = arg;
      rf_wdata = mem_rdata;
    end
  end

  // program counter
  logic [ADDR_W-1:0] pc_q, pc_d, ptr;
  logic              pc_en;

  assign ptr = {ptr_hi, ptr_lo};

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q + ADDR_W'(1);
    if (phase == PH_FETCH) begin
      pc_en = 1'b1;
    end else if (in_wb && cond_hold) begin
      if (opc == OP_SKIP) begin
        pc_en = 1'b1;
      end else if (opc == OP_JUMP) begin
        pc_en = 1'b1;
        pc_d  = ptr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) pc_q <= '0;
    else if (pc_en)  pc_q <= pc_d;
  end

  // memory port
  assign mem_addr  = (phase == PH_FETCH) ? pc_q : ptr;
  assign mem_we    = in_wb && (opc == OP_WB);
  assign mem_wdata = rf_rdata;

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk
  import accum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_ni,
  input phase_e              phase,
  input logic [2*DATA_W-1:0] pc,
  input logic [DATA_W-1:0]   ir,
  input logic [DATA_W-1:0]   acc,
  input logic [2*DATA_W-1:0] ptr,
  input logic                mem_we,
  input logic [2*DATA_W-1:0] mem_addr
);

  logic       is_branch;
  logic [3:0] opc;

  assign opc       = ir[DATA_W-1 -: 4];
  assign is_branch = (opc == OP_SKIP) || (opc == OP_JUMP);

  // R2: phases rotate fetch -> execute -> writeback
  assert_fetch_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_FETCH) |=> (phase == PH_EXEC));
  assert_exec_to_wb_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_EXEC) |=> (phase == PH_WB));
  assert_wb_to_fetch_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_WB) |=> (phase == PH_FETCH));

  // R2: counter steps by one across each fetch
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_FETCH) |=> (pc == $past(pc) + 1'b1));

  // R6: writes only in writeback, at the pointer
  assert_we_phase_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |-> (phase == PH_WB && mem_addr == ptr));

  // R3: immediate add wraps modulo 256
  assert_addi_wrap_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_WB && opc == OP_ADDI) |=>
      (acc == DATA_W'($past(acc) + DATA_W'($past(ir[3:0])))));

  // R9: branches leave the accumulator alone
  assert_branch_keeps_acc_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_WB && is_branch) |=> $stable(acc));

  // R11: codes 5..15 never redirect
  assert_never_cond_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_WB && is_branch && ir[3:0] >= 4'd5) |=> $stable(pc));

endmodule

bind accum_core accum_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_ni   (rst_core_n),
  .phase    (phase),
  .pc       (pc_q),
  .ir       (ir_q),
  .acc      (acc),
  .ptr      (ptr),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/accum_core_tb_top.sv
module accum_core_tb_top;
  import accum_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  accum_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // synchronous memory model
  logic [7:0] mem [0:65535];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    int          ord;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int n_checks = 0;
  int n_errs   = 0;
  int at       = 0;
  int ord      = 0;
  int cyc      = 0;
  int base_cyc = -1;
  int base_ord = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic emit(input opcode_e op, input logic [3:0] arg, input bit runs);
    mem[at] <= {op, arg};
    at++;
    if (runs) ord++;
  endtask

  task automatic store(input logic [3:0] r, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
    exp_q.push_back('{addr: a, data: d, ord: ord, tag: tag});
    emit(OP_WB, r, 1'b1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected store addr", int'(mem_addr), 0);
      end else begin
        cur = exp_q.pop_front();
        check(mem_addr == cur.addr, cur.tag, "store address", int'(mem_addr), int'(cur.addr));
        check(mem_wdata == cur.data, cur.tag, "store data", int'(mem_wdata), int'(cur.data));
        if (base_cyc < 0) begin
          base_cyc = cyc;
          base_ord = cur.ord;
        end else begin
          check((cyc - base_cyc) == 3 * (cur.ord - base_ord), "R2",
                "cycle spacing", cyc - base_cyc, 3 * (cur.ord - base_ord));
        end
      end
    end
  end

  initial begin
    int wd;
    rst_n = 1'b0;
    for (int i = 0; i < 65536; i++) mem[i] <= 8'h00;
    mem[16'h0101] <= 8'h3C;
    mem[16'h0102] <= 8'h50;

    // pointer setup (R1: low byte resets to 0)
    emit(OP_ADDI, 4'd1, 1);  emit(OP_SET, 4'd13, 1);
    emit(OP_ANDI, 4'd0, 1);  emit(OP_ADDI, 4'd5, 1);
    emit(OP_SET, 4'd1, 1);   emit(OP_ADDI, 4'd15, 1);
    store(4'd0, 16'h0100, 8'h14, "R1 R3 ADDI");
    emit(OP_SUB, 4'd1, 1);   emit(OP_SUBI, 4'd15, 1);
    emit(OP_SUBI, 4'd1, 1);
    store(4'd0, 16'h0100, 8'hFF, "R3 wrap");
    // R4 logic ops
    emit(OP_XORI, 4'hF, 1);  emit(OP_SET, 4'd2, 1);
    emit(OP_ANDI, 4'd0, 1);  emit(OP_ADDI, 4'hA, 1);
    emit(OP_OR, 4'd2, 1);
    store(4'd0, 16'h0100, 8'hFA, "R4 OR");
    emit(OP_ANDI, 4'hC, 1);  emit(OP_XOR, 4'd2, 1);
    emit(OP_ORI, 4'h3, 1);
    store(4'd0, 16'h0100, 8'hFB, "R4 ANDI XOR ORI");
    // R5 moves
    emit(OP_GET, 4'd1, 1);
    store(4'd0, 16'h0100, 8'h05, "R5 GET");
    store(4'd2, 16'h0100, 8'hF0, "R5 SET");
    // R7 loads
    emit(OP_ANDI, 4'd0, 1);  emit(OP_ADDI, 4'd1, 1);
    emit(OP_SET, 4'd14, 1);  emit(OP_RB, 4'd3, 1);
    emit(OP_ANDI, 4'd0, 1);  emit(OP_SET, 4'd14, 1);
    store(4'd3, 16'h0100, 8'h3C, "R7 RB");
    emit(OP_RB, 4'd14, 1);
    store(4'd3, 16'h013C, 8'h3C, "R7 RB into pointer");
    emit(OP_ANDI, 4'd0, 1);  emit(OP_SET, 4'd14, 1);
    emit(OP_RB, 4'd0, 1);    emit(OP_ADDI, 4'd1, 1);
    store(4'd0, 16'h0100, 8'h3D, "R7 RB to acc");
    // R8/R9 skips, compare register = 0x3D
    emit(OP_SET, 4'd15, 1);
    emit(OP_SKIP, 4'd1, 1);  emit(OP_WB, 4'd1, 0);
    store(4'd2, 16'h0100, 8'hF0, "R8 R9 skip eq taken");
    emit(OP_SKIP, 4'd2, 1);
    store(4'd1, 16'h0100, 8'h05, "R8 R9 skip ne false");
    emit(OP_SUBI, 4'd1, 1);
    emit(OP_SKIP, 4'd3, 1);  emit(OP_WB, 4'd2, 0);
    store(4'd1, 16'h0100, 8'h05, "R8 skip ltu taken");
    emit(OP_SKIP, 4'd4, 1);
    store(4'd0, 16'h0100, 8'h3C, "R8 skip gtu false");
    emit(OP_SKIP, 4'd5, 1);
    store(4'd2, 16'h0100, 8'hF0, "R8 skip never");
    emit(OP_SKIP, 4'd9, 1);
    store(4'd1, 16'h0100, 8'h05, "R11 skip code 9");
    emit(OP_ADDI, 4'd2, 1);
    emit(OP_SKIP, 4'd4, 1);  emit(OP_WB, 4'd1, 0);
    store(4'd0, 16'h0100, 8'h3E, "R8 skip gtu taken");
    // R10 jumps: pointer to 0x0050
    emit(OP_ANDI, 4'd0, 1);  emit(OP_ADDI, 4'd2, 1);
    emit(OP_SET, 4'd14, 1);  emit(OP_RB, 4'd5, 1);
    emit(OP_ANDI, 4'd0, 1);  emit(OP_SET, 4'd13, 1);
    emit(OP_GET, 4'd5, 1);   emit(OP_SET, 4'd14, 1);
    emit(OP_JUMP, 4'd5, 1);  emit(OP_JUMP, 4'd2, 1);
    while (at < 16'h0050) emit(OP_WB, 4'd1, 0);
    store(4'd0, 16'h0050, 8'h50, "R10 jump ne taken");
    emit(OP_JUMP, 4'd1, 1);  emit(OP_ADDI, 4'd15, 1);
    emit(OP_ADDI, 4'd1, 1);  emit(OP_SET, 4'd14, 1);
    emit(OP_JUMP, 4'd0, 1);
    while (at < 16'h0060) emit(OP_WB, 4'd1, 0);
    store(4'd0, 16'h0060, 8'h60, "R10 jump always");
    emit(OP_JUMP, 4'd3, 1);
    store(4'd1, 16'h0060, 8'h05, "R10 jump ltu false");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_we == 1'b0, "R1", "mem_we in reset", int'(mem_we), 0);
    check(mem_addr == 16'h0000, "R1", "mem_addr in reset", int'(mem_addr), 0);
    rst_n = 1'b1;

    wd = 0;
    while (exp_q.size() != 0 && wd < 4000) begin
      @(negedge clk);
      wd++;
    end
    check(exp_q.size() == 0, "WATCHDOG", "stores left", exp_q.size(), 0);
    repeat (30) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule